// File: doc/BRIEF.md
# Linked-List Command Chain Walker

The block follows a chain of command nodes kept in a 2 MB word-addressed memory and forwards the payload of each node, one word at a time, to a downstream command framer. Every node begins with one header word. The header holds the number of payload words in the node and the byte address of the node that comes next. The walker reads the header, then the payload words that sit directly after it, and then moves on to the next node. It stops when the address it is about to visit has its terminating bit set.

While it walks, the block keeps a nominal cost total, which grows by a fixed overhead plus the payload length for every node. It also keeps a progress value that always names the next address to be visited. Software or a DMA front end pulses `start` with a 32-bit start address. It then consumes the payload stream and waits for the one-cycle `done` pulse. After that it reads the final progress and the cost total, which stay unchanged until the next walk starts.

Memory is reached through a plain request/response read port with at most one read outstanding. The payload leaves through a valid/ready stream and is held stable under backpressure.

Top module: `chain_walker`

## Requirements
- R1: A `start` pulse while idle begins a walk at `start_addr[23:0]`, and bits [31:24] of `start_addr` are ignored. On the next cycle `busy` is high, `progress` equals the masked start address and `cycle_total` is 0.
- R2: Before any header is fetched, the address about to be visited is tested. If its bit 23 is set, the walk ends without a read. A start address with bit 23 set ends at once with no memory read, no payload and a `cycle_total` of 0.
- R3: A header word carries the payload length in bits [31:24] (0 to 255) and the next-node byte address in bits [23:0].
- R4: A node at byte address A has its header at memory word index A[20:2]. Address bits [23:21] and [1:0] do not affect the index. Its payload words sit at the following indices, and the index wraps modulo 2^19.
- R5: A node forwards exactly its length of payload words on `out_data`, in ascending index order. A node of length 0 forwards none, and nothing is forwarded while idle.
- R6: Every completed node adds 5 plus its length to `cycle_total`.
- R7: After each node, `progress` takes the next-node address from that node's header. The sequence of values it takes during a walk is the start address followed by each node's next address.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. No payload word is lost or repeated under any ready pattern.
- R9: `done` is a one-cycle pulse with `busy` low, given once per walk. After it, `cycle_total` and `progress` hold until the next accepted start.
- R10: A `start` pulse while `busy` is high is ignored and does not change the running walk's output.
- R11: `mem_req` is a one-cycle pulse, and no new read is issued before the previous response arrives. A walk issues one read per node plus one per payload word.
- R12: After reset, `busy`, `done`, `out_valid` and `mem_req` are low, and `cycle_total` and `progress` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a walk (accepted only while idle) |
| start_addr | input | 32 | Byte address of the first node; upper byte ignored |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse when the walk reaches the end marker |
| mem_req | output | 1 | Read request pulse |
| mem_idx | output | MEM_AW-2 (19) | Word index of the read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| out_valid | output | 1 | Payload word valid |
| out_data | output | 32 | Payload word |
| out_ready | input | 1 | Downstream accepts the word |
| progress | output | 24 | Next address to be visited |
| cycle_total | output | CYC_W (32) | Accumulated nominal node cost |

## Verification
The bench builds the walker with its default parameters: a 21-bit memory byte address, bit 23 as the end marker, an overhead of 5 and a 32-bit cost total. With these values the real 2 MB aliasing of addresses above bit 20 can be reached, as can the wrap of the payload index from 0x7FFFF back to 0. The full 8-bit length range can also be reached, so a 255-word node is walked. The bench's memory model answers two cycles after each request. A pseudo-random ready pattern stretches the payload stream, so the hold behaviour is exercised across many stall lengths.

// File: rtl/chain_walker_pkg.sv
// Shared definitions for the command chain walker: word and field widths,
// the controller state encoding and the node header layout.
package chain_walker_pkg;

    localparam int WORD_W = 32;   // memory and stream word width
    localparam int LEN_W  = 8;    // payload length field width
    localparam int LINK_W = 24;   // next-node address field width

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_HDR_REQ,
        ST_HDR_WAIT,
        ST_PAY_REQ,
        ST_PAY_WAIT,
        ST_PAY_OUT,
        ST_NODE_END
    } walk_state_t;

    // Header word: length in the top byte, link in the low 24 bits.
    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic [LINK_W-1:0] link;
    } node_hdr_t;

endpackage

// File: rtl/chain_hdr_split.sv
// Splits a raw header word into its length and link fields.
// Assumes the header layout of node_hdr_t; purely combinational.
module chain_hdr_split
    import chain_walker_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output logic [LEN_W-1:0]  len_o,
    output logic [LINK_W-1:0] link_o,
    output logic              empty_o
);

    node_hdr_t hdr;

    // Reinterpret the word as a header and expose its fields.
    always_comb begin
        hdr     = node_hdr_t'(word_i);
        len_o   = hdr.len;
        link_o  = hdr.link;
        empty_o = (hdr.len == '0);
    end

endmodule

// File: rtl/chain_walk_ctrl.sv
// Traversal controller: tests the end marker, fetches each header, then
// fetches and forwards the payload one word at a time.
// Assumes memory answers each request exactly once and that only one read
// is outstanding; responses outside a wait state are ignored.
module chain_walk_ctrl
    import chain_walker_pkg::*;
#(
    parameter  int MEM_AW  = 21,
    parameter  int END_BIT = 23,
    localparam int IDX_W   = MEM_AW - 2
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LINK_W-1:0] start_link_i,
    output logic              mem_req_o,
    output logic [IDX_W-1:0]  mem_idx_o,
    input  logic              mem_rsp_valid_i,
    input  logic [WORD_W-1:0] mem_rsp_data_i,
    input  logic [LEN_W-1:0]  hdr_len_i,
    input  logic [LINK_W-1:0] hdr_link_i,
    input  logic              hdr_empty_i,
    output logic              out_valid_o,
    output logic [WORD_W-1:0] out_data_o,
    input  logic              out_ready_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              walk_start_o,
    output logic              node_end_o,
    output logic [LEN_W-1:0]  node_len_o,
    output logic [LINK_W-1:0] node_link_o
);

    walk_state_t       state;
    logic [LINK_W-1:0] cur_link;
    logic [IDX_W-1:0]  word_ptr;
    logic [LEN_W-1:0]  remain;
    logic [LEN_W-1:0]  node_len_q;
    logic [LINK_W-1:0] node_link_q;
    logic [WORD_W-1:0] data_q;
    logic              done_q;
    logic              unused_link_bits;

    // Only the marker bit and the index bits of the link steer the walk.
    assign unused_link_bits = ^cur_link;

    // Main traversal sequence and its address, count and data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cur_link    <= '0;
            word_ptr    <= '0;
            remain      <= '0;
            node_len_q  <= '0;
            node_link_q <= '0;
            data_q      <= '0;
            done_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        cur_link <= start_link_i;
                        state    <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (cur_link[END_BIT]) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        word_ptr <= cur_link[MEM_AW-1:2];
                        state    <= ST_HDR_REQ;
                    end
                end
                ST_HDR_REQ: begin
                    state <= ST_HDR_WAIT;
                end
                ST_HDR_WAIT: begin
                    if (mem_rsp_valid_i) begin
                        node_len_q  <= hdr_len_i;
                        node_link_q <= hdr_link_i;
                        remain      <= hdr_len_i;
                        word_ptr    <= word_ptr + IDX_W'(1);
                        state       <= hdr_empty_i ? ST_NODE_END : ST_PAY_REQ;
                    end
                end
                ST_PAY_REQ: begin
                    state <= ST_PAY_WAIT;
                end
                ST_PAY_WAIT: begin
                    if (mem_rsp_valid_i) begin
                        data_q <= mem_rsp_data_i;
                        state  <= ST_PAY_OUT;
                    end
                end
                ST_PAY_OUT: begin
                    if (out_ready_i) begin
                        word_ptr <= word_ptr + IDX_W'(1);
                        remain   <= remain - LEN_W'(1);
                        state    <= (remain == LEN_W'(1)) ? ST_NODE_END : ST_PAY_REQ;
                    end
                end
                ST_NODE_END: begin
                    cur_link <= node_link_q;
                    state    <= ST_CHECK;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port-side decode of the current state.
    always_comb begin
        mem_req_o    = (state == ST_HDR_REQ) || (state == ST_PAY_REQ);
        mem_idx_o    = word_ptr;
        out_valid_o  = (state == ST_PAY_OUT);
        out_data_o   = data_q;
        busy_o       = (state != ST_IDLE);
        done_o       = done_q;
        walk_start_o = (state == ST_IDLE) && start_i;
        node_end_o   = (state == ST_NODE_END);
        node_len_o   = node_len_q;
        node_link_o  = node_link_q;
    end

endmodule

// File: rtl/chain_cost_acc.sv
// Keeps the nominal walk cost and the progress address.
// Assumes walk_start and node_end never coincide (the controller guarantees it).
module chain_cost_acc
    import chain_walker_pkg::*;
#(
    parameter int CYC_W    = 32,
    parameter int OVERHEAD = 5
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              walk_start_i,
    input  logic [LINK_W-1:0] start_link_i,
    input  logic              node_end_i,
    input  logic [LEN_W-1:0]  node_len_i,
    input  logic [LINK_W-1:0] node_link_i,
    output logic [CYC_W-1:0]  total_o,
    output logic [LINK_W-1:0] progress_o
);

    localparam logic [CYC_W-1:0] OVH = CYC_W'(OVERHEAD);

    // Clear on a new walk, add overhead plus length on each finished node.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total_o    <= '0;
            progress_o <= '0;
        end else if (walk_start_i) begin
            total_o    <= '0;
            progress_o <= start_link_i;
        end else if (node_end_i) begin
            total_o    <= total_o + OVH + CYC_W'(node_len_i);
            progress_o <= node_link_i;
        end
    end

endmodule

// File: rtl/chain_walker.sv
// Top level of the command chain walker. Masks the start address, wires the
// header splitter, the traversal controller and the cost accumulator.
// Assumes a memory with one outstanding read and a valid/ready sink.
module chain_walker
    import chain_walker_pkg::*;
#(
    parameter  int MEM_AW   = 21,
    parameter  int END_BIT  = 23,
    parameter  int CYC_W    = 32,
    parameter  int OVERHEAD = 5,
    localparam int IDX_W    = MEM_AW - 2
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] start_addr,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic [IDX_W-1:0]  mem_idx,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    input  logic              out_ready,
    output logic [LINK_W-1:0] progress,
    output logic [CYC_W-1:0]  cycle_total
);

    logic [LINK_W-1:0] start_link;
    logic [LEN_W-1:0]  hdr_len;
    logic [LINK_W-1:0] hdr_link;
    logic              hdr_empty;
    logic              walk_start;
    logic              node_end;
    logic [LEN_W-1:0]  node_len;
    logic [LINK_W-1:0] node_link;
    logic              unused_start_hi;

    // Keep only the address field of the start word.
    assign start_link      = start_addr[LINK_W-1:0];
    assign unused_start_hi = ^start_addr[WORD_W-1:LINK_W];

    chain_hdr_split u_split (
        .word_i  (mem_rsp_data),
        .len_o   (hdr_len),
        .link_o  (hdr_link),
        .empty_o (hdr_empty)
    );

    chain_walk_ctrl #(
        .MEM_AW  (MEM_AW),
        .END_BIT (END_BIT)
    ) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start),
        .start_link_i    (start_link),
        .mem_req_o       (mem_req),
        .mem_idx_o       (mem_idx),
        .mem_rsp_valid_i (mem_rsp_valid),
        .mem_rsp_data_i  (mem_rsp_data),
        .hdr_len_i       (hdr_len),
        .hdr_link_i      (hdr_link),
        .hdr_empty_i     (hdr_empty),
        .out_valid_o     (out_valid),
        .out_data_o      (out_data),
        .out_ready_i     (out_ready),
        .busy_o          (busy),
        .done_o          (done),
        .walk_start_o    (walk_start),
        .node_end_o      (node_end),
        .node_len_o      (node_len),
        .node_link_o     (node_link)
    );

    chain_cost_acc #(
        .CYC_W    (CYC_W),
        .OVERHEAD (OVERHEAD)
    ) u_acc (
        .clk          (clk),
        .rst_n        (rst_n),
        .walk_start_i (walk_start),
        .start_link_i (start_link),
        .node_end_i   (node_end),
        .node_len_i   (node_len),
        .node_link_i  (node_link),
        .total_o      (cycle_total),
        .progress_o   (progress)
    );

endmodule

// File: rtl/chain_walker_sva.sv
// Protocol and state checks for chain_walker, attached with bind.
module chain_walker_sva #(
    parameter int CYC_W = 32
)(
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [31:0]      start_addr,
    input logic             busy,
    input logic             done,
    input logic             mem_req,
    input logic             out_valid,
    input logic [31:0]      out_data,
    input logic             out_ready,
    input logic [23:0]      progress,
    input logic [CYC_W-1:0] cycle_total
);

    // R1: an accepted start loads the masked address and clears the total
    assert_start_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy && progress == $past(start_addr[23:0]) && cycle_total == '0);

    // R5: no payload and no reads while idle
    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !out_valid && !mem_req);

    // R6: the total never shrinks during a walk
    assert_total_grow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> cycle_total >= $past(cycle_total));

    // R8: a stalled word holds
    assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R9: done is a single-cycle pulse seen while idle
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: results hold while idle and no start arrives
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(cycle_total) && $stable(progress));

    // R11: reads are single-cycle pulses, never alongside a payload offer
    assert_req_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    assert_req_vs_out_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !mem_req);

endmodule

bind chain_walker chain_walker_sva #(.CYC_W(CYC_W)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_addr  (start_addr),
    .busy        (busy),
    .done        (done),
    .mem_req     (mem_req),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_ready   (out_ready),
    .progress    (progress),
    .cycle_total (cycle_total)
);

// File: tb/tb_chain_walker.sv
// Directed bench for chain_walker: one task per scenario.
module tb_chain_walker;

    localparam int IDX_W = 19;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [31:0] start_addr;
    logic        busy, done, mem_req;
    logic [IDX_W-1:0] mem_idx;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_ready;
    logic [23:0] progress;
    logic [31:0] cycle_total;

    always #10 clk = ~clk;

    chain_walker dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .busy(busy), .done(done), .mem_req(mem_req), .mem_idx(mem_idx),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .progress(progress), .cycle_total(cycle_total)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [31:0] mem [int];
    logic        p1_v;
    logic [IDX_W-1:0] p1_a;

    logic [31:0] got_q[$], exp_q[$], got_prog[$], exp_prog[$];
    logic [31:0] exp_total;
    logic [23:0] last_exp, prev_prog;
    int          done_cnt, req_cnt;
    int          ready_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    function automatic logic [31:0] rd(input int unsigned i);
        if (mem.exists(int'(i))) return mem[int'(i)];
        return 32'h0;
    endfunction

    // Memory model: answers two cycles after each request.
    always @(negedge clk) begin
        if (!rst_n) begin
            p1_v <= 1'b0; p1_a <= '0; mem_rsp_valid <= 1'b0; mem_rsp_data <= '0;
        end else begin
            mem_rsp_valid <= p1_v;
            mem_rsp_data  <= rd(int'(p1_a));
            p1_v <= mem_req;
            p1_a <= mem_idx;
        end
    end

    // Ready pattern, changed just after each rising edge.
    always @(posedge clk) begin
        #1;
        if (ready_mode == 0) out_ready = 1'b1;
        else begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = lfsr[0];
        end
    end

    // Output monitor, sampling between edges.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && out_ready) got_q.push_back(out_data);
            if (progress != prev_prog) got_prog.push_back({8'h0, progress});
            if (done) done_cnt++;
            if (mem_req) req_cnt++;
        end
        prev_prog = progress;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic cmp_q(input string tag, input string what,
                         ref logic [31:0] a[$], ref logic [31:0] e[$]);
        bit ok = (a.size() == e.size());
        int bad = -1;
        if (ok) begin
            for (int i = 0; i < a.size(); i++)
                if (a[i] !== e[i] && bad < 0) bad = i;
            ok = (bad < 0);
        end
        if (!ok && bad >= 0)
            chk(0, tag, {what, " word"}, 64'(a[bad]), 64'(e[bad]));
        else
            chk(ok, tag, {what, " count"}, 64'(a.size()), 64'(e.size()));
    endtask

    task automatic exp_prog_push(input logic [23:0] v);
        if (v != last_exp) exp_prog.push_back({8'h0, v});
        last_exp = v;
    endtask

    // Start a fresh scenario: empty memory and expectations.
    task automatic prep(input logic [31:0] sa);
        mem.delete();
        exp_q.delete(); got_q.delete(); exp_prog.delete(); got_prog.delete();
        exp_total = 0;
        last_exp  = progress;
        exp_prog_push(sa[23:0]);
    endtask

    // Place one node; the word index follows R4 (byte address bits 20..2).
    task automatic place(input logic [31:0] baddr, input int len,
                         input logic [23:0] nxt, input logic [31:0] seed);
        int unsigned idx = (baddr & 32'h1FFFFF) >> 2;
        mem[int'(idx)] = {len[7:0], nxt};
        for (int i = 0; i < len; i++) begin
            mem[int'((idx + 1 + i) & 32'h7FFFF)] = seed + i;
            exp_q.push_back(seed + i);
        end
        exp_total += 5 + len;
        exp_prog_push(nxt);
    endtask

    // Pulse start, optionally inject a second start mid-walk, wait for done.
    task automatic run_walk(input logic [31:0] sa, input string tag,
                            input int inject_at, input logic [31:0] inj_addr);
        int n = 0;
        done_cnt = 0; req_cnt = 0;
        @(negedge clk); start = 1'b1; start_addr = sa;
        @(negedge clk); start = 1'b0;
        while (done_cnt == 0 && n < 20000) begin
            @(posedge clk); n++;
            if (n == inject_at) begin
                @(negedge clk); start = 1'b1; start_addr = inj_addr;
                @(negedge clk); start = 1'b0;
            end
        end
        repeat (3) @(negedge clk);
        chk(done_cnt == 1, tag, "done pulses (R9)", 64'(done_cnt), 64'd1);
        cmp_q(tag, "payload (R5)", got_q, exp_q);
        chk(cycle_total == exp_total, tag, "cycle_total (R6)", 64'(cycle_total), 64'(exp_total));
        cmp_q(tag, "progress sequence (R7)", got_prog, exp_prog);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !out_valid && !mem_req, "R12", "idle outputs",
            {60'h0, busy, done, out_valid, mem_req}, 64'h0);
        chk(cycle_total == 0 && progress == 0, "R12", "zero results",
            {8'h0, progress, cycle_total}, 64'h0);
    endtask

    task automatic t_single();
        prep(32'h0000_1000);
        place(32'h0000_1000, 3, 24'h80_0000, 32'h1111_0000);
        run_walk(32'h0000_1000, "R3", 0, 0);
        chk(progress == 24'h80_0000, "R7", "final progress", 64'(progress), 64'h80_0000);
    endtask

    task automatic t_multi();
        prep(32'h0000_2000);
        place(32'h0000_2000, 2, 24'h00_2100, 32'hA000_0000);
        place(32'h0000_2100, 0, 24'h00_2040, 32'h0);
        place(32'h0000_2040, 4, 24'hC0_0000, 32'hB000_0000);
        run_walk(32'h0000_2000, "R5", 0, 0);
        chk(exp_total == 21, "R6", "node cost sum", 64'(exp_total), 64'd21);
        chk(req_cnt == 9, "R11", "reads issued", 64'(req_cnt), 64'd9);
    endtask

    task automatic t_immediate_end();
        prep(32'h0080_0010);
        run_walk(32'h0080_0010, "R2", 0, 0);
        chk(req_cnt == 0, "R2", "reads on immediate end", 64'(req_cnt), 64'd0);
        chk(progress == 24'h80_0010, "R2", "progress", 64'(progress), 64'h80_0010);
    endtask

    task automatic t_mask();
        prep(32'hAB00_3000);
        place(32'h0000_3000, 1, 24'h80_ABCD, 32'h3333_0000);
        run_walk(32'hAB00_3000, "R1", 0, 0);
        chk(progress == 24'h80_ABCD, "R1", "final progress after masked start",
            64'(progress), 64'h80_ABCD);
    endtask

    task automatic t_alias_wrap();
        prep(32'h0030_3006);
        place(32'h0030_3006, 2, 24'h1F_FFF9, 32'h4444_0000);
        place(32'h001F_FFF9, 3, 24'h80_0000, 32'h5555_0000);
        run_walk(32'h0030_3006, "R4", 0, 0);
        chk(req_cnt == 7, "R4", "reads with wrap", 64'(req_cnt), 64'd7);
    endtask

    task automatic t_backpressure();
        ready_mode = 1;
        prep(32'h0000_6000);
        place(32'h0000_6000, 6, 24'h00_6100, 32'h6666_0000);
        place(32'h0000_6100, 5, 24'h80_0001, 32'h7777_0000);
        run_walk(32'h0000_6000, "R8", 0, 0);
        ready_mode = 0;
    endtask

    task automatic t_long_ignore();
        prep(32'h0000_4000);
        place(32'h0000_4000, 255, 24'h90_0000, 32'h8000_0000);
        mem[int'(32'h5000 >> 2)] = {8'd2, 24'h80_0002};
        run_walk(32'h0000_4000, "R10", 50, 32'h0000_5000);
        chk(exp_total == 260, "R10", "long node cost", 64'(exp_total), 64'd260);
    endtask

    task automatic t_hold();
        logic [31:0] tot = cycle_total;
        logic [23:0] prg = progress;
        got_q.delete(); got_prog.delete(); done_cnt = 0;
        repeat (30) @(negedge clk);
        chk(cycle_total == tot && progress == prg, "R9", "held results",
            {8'h0, progress, cycle_total}, {8'h0, prg, tot});
        chk(got_q.size() == 0 && done_cnt == 0 && !busy, "R9", "quiet while idle",
            64'(got_q.size() + done_cnt), 64'd0);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; start_addr = '0; out_ready = 1'b1;
        prev_prog = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_multi();
        t_immediate_end();
        t_mask();
        t_alias_wrap();
        t_backpressure();
        t_long_ignore();
        t_hold();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule